// File: doc/BRIEF.md
# Subword Permute and Interleave Unit

This block rearranges the contents of two 64-bit packed source registers into one 64-bit target register. It is purely combinational: the target reflects the sources, the opcode and the size select in the same cycle. Pipeline staging belongs to the surrounding execution stage.

Most operations treat the sources as lanes of 8, 16 or 32 bits, picked by the size select. Mix-left and mix-right pair up even or odd lanes of both sources. Unpack-low and unpack-high interleave one half of each source. Pack narrows every lane of both sources to half width.

A separate byte permute ignores the size select. A third 64-bit operand supplies one index per target byte, and each index can pick any of the sixteen bytes held in the two sources.

Lane numbering starts at the least significant end: lane j of an operand with lane width s occupies bits [j*s + s-1 : j*s].

Top module: `subword_perm_unit`

## Requirements
- R1: With opSel = 0 (mix-left) and a valid size, target lane 2k equals lane 2k of srcA and target lane 2k+1 equals lane 2k of srcB.
- R2: With opSel = 1 (mix-right), target lane 2k equals lane 2k+1 of srcA and target lane 2k+1 equals lane 2k+1 of srcB.
- R3: With opSel = 2 (unpack-low), for k below half the lane count, target lane 2k equals srcA lane k and target lane 2k+1 equals srcB lane k.
- R4: With opSel = 3 (unpack-high), target lane 2k equals srcA lane k+n/2 and target lane 2k+1 equals srcB lane k+n/2, where n is the lane count.
- R5: With opSel = 4 (pack), the low half of each srcA lane j fills half-width slot j of the target's lower 32 bits, and the low half of each srcB lane j fills slot j of the upper 32 bits.
- R6: With opSel = 5 (byte permute), target byte i equals byte number permCtl[8i+3:8i] of the 16-byte value {srcB, srcA}. Indices 0 to 7 name srcA bytes and 8 to 15 name srcB bytes.
- R7: In byte permute, bits [8i+7:8i+4] of permCtl have no effect on the target.
- R8: opSel values 6 and 7 are reserved and drive the target to all zeros.
- R9: sizeSel encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. The value 3 is reserved and zeroes the result of opSel 0 to 4, while byte permute ignores sizeSel entirely.
- R10: The target follows any input change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcA | input | 64 | First packed source |
| srcB | input | 64 | Second packed source |
| permCtl | input | 64 | Byte permute indices, one per target byte |
| opSel | input | 3 | Operation select |
| sizeSel | input | 2 | Lane width select |
| result | output | 64 | Target register value |

## Verification
There is no stored state, so a fault in the decoded strobes or in one lane path shows at the ports in the same cycle. A wrong size strobe puts a lane pattern of the wrong width on the target. A wrong operation strobe ORs two candidate results together or blanks the target. A crossed index in a lane loop misplaces one lane and leaves its neighbours correct. Random operands for every opcode and size catch such faults, and all-distinct byte patterns show exactly which lane moved.

// File: rtl/subword_perm_pkg.sv
package subword_perm_pkg;

  localparam int SIZE_COUNT = 3;
  localparam int MIN_LANE_W = 8;

  typedef enum logic [2:0] {
    OP_MIX_LEFT  = 3'd0,
    OP_MIX_RIGHT = 3'd1,
    OP_UNPK_LO   = 3'd2,
    OP_UNPK_HI   = 3'd3,
    OP_PACK      = 3'd4,
    OP_PERMUTE   = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } op_e;

  typedef struct packed {
    logic selMixL;
    logic selMixR;
    logic selUnLo;
    logic selUnHi;
    logic selPack;
    logic selPerm;
    logic [SIZE_COUNT-1:0] sizeHot;
  } strobe_t;

endpackage

// File: rtl/subword_perm_ctrl.sv
module subword_perm_ctrl
  import subword_perm_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic [1:0] sizeSel,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    case (op_e'(opSel))
      OP_MIX_LEFT:  strb.selMixL = 1'b1;
      OP_MIX_RIGHT: strb.selMixR = 1'b1;
      OP_UNPK_LO:   strb.selUnLo = 1'b1;
      OP_UNPK_HI:   strb.selUnHi = 1'b1;
      OP_PACK:      strb.selPack = 1'b1;
      OP_PERMUTE:   strb.selPerm = 1'b1;
      default:      strb = '0;
    endcase
    for (int z = 0; z < SIZE_COUNT; z++) begin
      strb.sizeHot[z] = (int'(sizeSel) == z);
    end
  end

endmodule

// File: rtl/subword_perm_dp.sv
module subword_perm_dp
  import subword_perm_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]                           srcA,
  input  logic [WIDTH-1:0]                           srcB,
  input  logic [WIDTH/8-1:0][$clog2(2*WIDTH/8)-1:0]  permIdx,
  input  strobe_t                                    strb,
  output logic [WIDTH-1:0]                           result
);

  localparam int NBYTE = WIDTH / 8;
  localparam int IDXW  = $clog2(2 * NBYTE);

  logic [SIZE_COUNT-1:0][WIDTH-1:0] mixLAll, mixRAll, unLoAll, unHiAll, packAll;
  logic [WIDTH-1:0] laneRes;
  logic [WIDTH-1:0] permRes;
  logic [2*WIDTH-1:0] catBA;

  generate
    for (genvar z = 0; z < SIZE_COUNT; z++) begin : g_size
      localparam int SW = MIN_LANE_W << z;
      localparam int N  = WIDTH / SW;
      localparam int HW = SW / 2;
      logic [WIDTH-1:0] mixL, mixR, unLo, unHi, pk;
      always_comb begin
        for (int k = 0; k < N / 2; k++) begin
          mixL[(2*k)*SW +: SW]   = srcA[(2*k)*SW +: SW];
          mixL[(2*k+1)*SW +: SW] = srcB[(2*k)*SW +: SW];
          mixR[(2*k)*SW +: SW]   = srcA[(2*k+1)*SW +: SW];
          mixR[(2*k+1)*SW +: SW] = srcB[(2*k+1)*SW +: SW];
          unLo[(2*k)*SW +: SW]   = srcA[k*SW +: SW];
          unLo[(2*k+1)*SW +: SW] = srcB[k*SW +: SW];
          unHi[(2*k)*SW +: SW]   = srcA[(k+N/2)*SW +: SW];
          unHi[(2*k+1)*SW +: SW] = srcB[(k+N/2)*SW +: SW];
        end
        for (int j = 0; j < N; j++) begin
          pk[j*HW +: HW]           = srcA[j*SW +: HW];
          pk[WIDTH/2 + j*HW +: HW] = srcB[j*SW +: HW];
        end
      end
      assign mixLAll[z] = mixL;
      assign mixRAll[z] = mixR;
      assign unLoAll[z] = unLo;
      assign unHiAll[z] = unHi;
      assign packAll[z] = pk;
    end
  endgenerate

  always_comb begin
    laneRes = '0;
    for (int z = 0; z < SIZE_COUNT; z++) begin
      laneRes = laneRes | ({WIDTH{strb.sizeHot[z]}} & (
                  ({WIDTH{strb.selMixL}} & mixLAll[z]) |
                  ({WIDTH{strb.selMixR}} & mixRAll[z]) |
                  ({WIDTH{strb.selUnLo}} & unLoAll[z]) |
                  ({WIDTH{strb.selUnHi}} & unHiAll[z]) |
                  ({WIDTH{strb.selPack}} & packAll[z])));
    end
  end

  assign catBA = {srcB, srcA};

  generate
    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
      logic [IDXW-1:0] pick;
      assign pick = permIdx[i];
      assign permRes[i*8 +: 8] = catBA[int'(pick)*8 +: 8];
    end
  endgenerate

  assign result = laneRes | ({WIDTH{strb.selPerm}} & permRes);

endmodule

// File: rtl/subword_perm_unit.sv
module subword_perm_unit
  import subword_perm_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [WIDTH-1:0] permCtl,
  input  logic [2:0]       opSel,
  input  logic [1:0]       sizeSel,
  output logic [WIDTH-1:0] result
);

  localparam int NBYTE = WIDTH / 8;
  localparam int IDXW  = $clog2(2 * NBYTE);

  strobe_t strb;
  logic [NBYTE-1:0][IDXW-1:0] permIdx;

  always_comb begin
    for (int i = 0; i < NBYTE; i++) begin
      permIdx[i] = permCtl[i*8 +: IDXW];
    end
  end

  subword_perm_ctrl u_ctrl (
    .opSel   (opSel),
    .sizeSel (sizeSel),
    .strb    (strb)
  );

  subword_perm_dp #(.WIDTH(WIDTH)) u_dp (
    .srcA    (srcA),
    .srcB    (srcB),
    .permIdx (permIdx),
    .strb    (strb),
    .result  (result)
  );

endmodule

// File: rtl/subword_perm_checker.sv
module subword_perm_checker #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] srcA,
  input logic [WIDTH-1:0] srcB,
  input logic [WIDTH-1:0] permCtl,
  input logic [2:0]       opSel,
  input logic [1:0]       sizeSel,
  input logic [WIDTH-1:0] result
);

  logic [2*WIDTH-1:0] catBA;
  assign catBA = {srcB, srcA};

  always_comb begin
    if (opSel == 3'd0 && sizeSel != 2'd3)
      p_mixl_low_byte_r1: assert (result[7:0] == srcA[7:0]);
    if (opSel == 3'd1 && sizeSel == 2'd0)
      p_mixr_low_byte_r2: assert (result[7:0] == srcA[15:8]);
    if (opSel == 3'd2 && sizeSel == 2'd0)
      p_unlo_second_byte_r3: assert (result[15:8] == srcB[7:0]);
    if (opSel == 3'd3 && sizeSel != 2'd3)
      p_unhi_top_byte_r4: assert (result[WIDTH-1 -: 8] == srcB[WIDTH-1 -: 8]);
    if (opSel == 3'd4 && sizeSel != 2'd3)
      p_pack_halves_r5: assert (result[3:0] == srcA[3:0] &&
                                result[WIDTH/2 +: 4] == srcB[3:0]);
    if (opSel == 3'd5)
      p_perm_byte0_r6: assert (result[7:0] == catBA[int'(permCtl[3:0])*8 +: 8]);
    if (opSel[2:1] == 2'b11)
      p_rsvd_op_zero_r8: assert (result == '0);
    if (sizeSel == 2'd3 && opSel < 3'd5)
      p_rsvd_size_zero_r9: assert (result == '0);
  end

endmodule

bind subword_perm_unit subword_perm_checker #(.WIDTH(WIDTH)) u_checker (
  .srcA    (srcA),
  .srcB    (srcB),
  .permCtl (permCtl),
  .opSel   (opSel),
  .sizeSel (sizeSel),
  .result  (result)
);

// File: tb/subword_perm_unit_bench.sv
`timescale 1ns/1ps
module subword_perm_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] srcA, srcB, permCtl, result;
  logic [2:0]  opSel;
  logic [1:0]  sizeSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  subword_perm_unit u_subword_perm_unit (
    .srcA(srcA), .srcB(srcB), .permCtl(permCtl),
    .opSel(opSel), .sizeSel(sizeSel), .result(result)
  );

  function automatic logic [63:0] lane(input logic [63:0] x, input int idx, input int sw);
    logic [63:0] m;
    m = (sw == 64) ? '1 : ((64'd1 << sw) - 64'd1);
    return (x >> (idx * sw)) & m;
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] sz,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] c);
    logic [63:0] r;
    int sw, n, hw, idx;
    r = '0;
    if (op == 3'd5) begin
      for (int i = 0; i < 8; i++) begin
        idx = int'(c[8*i +: 4]);
        r |= (idx < 8 ? lane(a, idx, 8) : lane(b, idx - 8, 8)) << (8 * i);
      end
      return r;
    end
    if (op > 3'd5 || sz == 2'd3) return '0;
    sw = 8 << sz; n = 64 / sw; hw = sw / 2;
    if (op == 3'd4) begin
      for (int j = 0; j < n; j++) begin
        r |= lane(lane(a, j, sw), 0, hw) << (j * hw);
        r |= lane(lane(b, j, sw), 0, hw) << (32 + j * hw);
      end
      return r;
    end
    for (int j = 0; j < n; j++) begin
      case (op)
        3'd0: idx = j & ~1;
        3'd1: idx = j | 1;
        3'd2: idx = j >> 1;
        default: idx = (j >> 1) + n / 2;
      endcase
      r |= lane((j % 2 == 0) ? a : b, idx, sw) << (j * sw);
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] op, input logic [1:0] sz);
    if (op > 3'd5) return "R8";
    if (op == 3'd5) return "R6";
    if (sz == 2'd3) return "R9";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d size=%0d got %h expected %h", tag, opSel, sizeSel, result, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(posedge clk);
    opSel = op; sizeSel = sz; srcA = a; srcB = b; permCtl = c;
    @(negedge clk);
  endtask

  localparam logic [63:0] PA = 64'h0706050403020100;
  localparam logic [63:0] PB = 64'h0F0E0D0C0B0A0908;

  initial begin
    srcA = '0; srcB = '0; permCtl = '0; opSel = '0; sizeSel = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", 64'd0);

    // directed lane cases with distinct bytes
    for (int op = 0; op < 5; op++) begin
      for (int sz = 0; sz < 3; sz++) begin
        apply(3'(op), 2'(sz), PA, PB, '0);
        check(tagOf(3'(op), 2'(sz)), model(3'(op), 2'(sz), PA, PB, '0));
      end
    end
    // spot values worked out from R1..R5
    apply(3'd0, 2'd0, PA, PB, '0); check("R1 byte", 64'h0E060C040A020800);
    apply(3'd1, 2'd1, PA, PB, '0); check("R2 half", 64'h0F0E07060B0A0302);
    apply(3'd2, 2'd2, PA, PB, '0); check("R3 word", 64'h0B0A090803020100);
    apply(3'd3, 2'd0, PA, PB, '0); check("R4 byte", 64'h0F070E060D050C04);
    apply(3'd4, 2'd0, PA, PB, '0); check("R5 nibble", 64'hFEDCBA9876543210);

    // R6 identity and full swap
    apply(3'd5, 2'd0, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, PA);
    check("R6 identity", 64'h1122334455667788);
    apply(3'd5, 2'd0, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, PB);
    check("R6 select b", 64'h99AABBCCDDEEFF00);
    apply(3'd5, 2'd0, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, 64'h000102030405060F);
    check("R6 reverse", 64'h8877665544332299);
    // R7 upper nibbles ignored
    apply(3'd5, 2'd0, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, 64'hF0A0B0C0D0E0908F);
    check("R7 upper nibble", 64'h8888888888888899);
    // R8 reserved opcodes
    apply(3'd6, 2'd0, PA, PB, PA); check("R8 op6", 64'd0);
    apply(3'd7, 2'd1, PA, PB, PA); check("R8 op7", 64'd0);
    // R9 reserved size
    apply(3'd0, 2'd3, PA, PB, '0); check("R9 lane op", 64'd0);
    apply(3'd5, 2'd3, PA, PB, 64'h0001020304050607); check("R9 perm", 64'h0001020304050607);
    // R10 combinational: change inputs mid-cycle, no edge
    @(negedge clk);
    opSel = 3'd2; sizeSel = 2'd0; srcA = PA; srcB = PB;
    #1;
    check("R10 no edge", 64'h0B030A0209010800);

    void'($urandom(32'd20240607));
    for (int t = 0; t < 3000; t++) begin
      logic [63:0] ra, rb, rc;
      logic [2:0] rop;
      logic [1:0] rsz;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rc = {$urandom, $urandom};
      rop = 3'($urandom % 8); rsz = 2'($urandom % 4);
      apply(rop, rsz, ra, rb, rc);
      check(tagOf(rop, rsz), model(rop, rsz, ra, rb, rc));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule